// File: doc/BRIEF.md
# Linked-Descriptor Transmit DMA Engine

This block walks a chain of transmit descriptors held in a word-addressed memory and turns each descriptor's buffer into a byte stream. The byte stream is cut into packets of at most `cfg_max_pkt` bytes. Software builds the chain in memory, marks each descriptor as owned by the engine, and writes the address of the first descriptor to the head port. The engine reads each descriptor, streams its bytes with start and end markers, and hands the descriptor back by rewriting its mode word with the ownership flag cleared.

A descriptor is four consecutive 32-bit words. When a descriptor has no successor, the engine marks it end-of-queue and goes idle, and software restarts the engine by writing the head port again. A special descriptor requests zero-length packets instead of data. Every release raises an interrupt. The interrupt stays up until software writes the address of the last released descriptor to the completion port.

States:
- `ST_IDLE` waits for a head write. `ST_IDLE -> ST_RD_NEXT` happens on a valid start.
- `ST_RD_NEXT -> ST_RD_BUF -> ST_RD_LEN -> ST_RD_MODE -> ST_EVAL` read the four descriptor words in a pipeline.
- `ST_EVAL` decides what to do with the descriptor:
  - `-> ST_IDLE` if the descriptor is not owned.
  - `-> ST_ZLP` for a zero-length-packet request with a nonzero buffer pointer.
  - `-> ST_RETIRE` for a zero-length-packet request with a zero buffer pointer, or for a length of zero.
  - `-> ST_FETCH` otherwise.
- The data loop runs `ST_FETCH -> ST_LATCH -> ST_EMIT`. From `ST_EMIT` the engine stays put for the next byte in the same word, goes to `ST_FETCH` at a word boundary, and goes to `ST_RETIRE` after the last byte.
- `ST_ZLP` repeats once per zero-length packet and then goes to `ST_RETIRE`.
- `ST_RETIRE` writes the mode word back. It goes to `ST_RD_NEXT` if a successor exists, and to `ST_IDLE` if not.

Top module: `tdma_engine`

## Requirements
- R1: A descriptor at word address D holds the following words:
  - D+0: next-descriptor word address (0 means none).
  - D+1: buffer byte pointer.
  - D+2: byte offset in bits 31:16 and byte length in bits 15:0.
  - D+3: the mode word.

  The engine sends the length bytes that start at byte address pointer+offset, in increasing address order. Byte address b lives in memory word b>>2, bits 8*(b mod 4)+7 down to 8*(b mod 4).
- R2: Packet framing works as follows:
  - `tx_sop` marks the first byte of a packet.
  - `tx_eop` marks the byte that brings the packet to `cfg_max_pkt` bytes, or the last byte of a descriptor whose mode bit 30 (end of frame) is set.
  - Without bit 30, the packet continues into the next descriptor.
  - Mode bit 31 (start of frame) in an owned descriptor restarts packet counting.
- R3: Only a descriptor whose mode bit 29 (ownership) is set is processed. On an unowned descriptor the engine goes idle with no output, no memory write and no interrupt.
- R4: After finishing an owned descriptor, the engine writes its mode word back to D+3 with bit 29 cleared and all other bits kept. It then follows the next pointer when that pointer is nonzero.
- R5: When the next pointer is zero, the written-back mode word also has bit 28 (end of queue) set and the engine becomes idle. A later head write in idle restarts it. A head write of 0 is ignored.
- R6: A descriptor with mode bit 23 set sends no data bytes. Instead it emits ((L-1)/cfg_max_pkt)+1 zero-length packets, where L is the length field and L=0 counts as one packet. Each zero-length packet is one cycle with `tx_valid`, `tx_sop`, `tx_eop` and `tx_zlp` all high.
- R7: A zero-length-packet descriptor whose whole buffer pointer word is zero emits nothing, sets `err`, and is still released as in R4/R5.
- R8: Each release raises `irq`. `irq` stays high until a completion write carries exactly the address of the most recently released descriptor. Any other completion value leaves it high.
- R9: A head write while `busy` is high is ignored: it changes neither the stream nor the memory. It sets `err`, which stays set until reset.
- R10: An owned descriptor with length 0 and bit 23 clear emits no bytes and is released normally.
- R11: After reset, `busy`, `irq`, `err`, `tx_valid`, `mem_rd` and `mem_wr` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_max_pkt | input | PKT_W | Maximum packet size in bytes (nonzero) |
| hdp_wr | input | 1 | Head-pointer write strobe |
| hdp_wdata | input | ADDR_W | First descriptor word address |
| cmpl_wr | input | 1 | Completion-pointer write strobe |
| cmpl_wdata | input | ADDR_W | Acknowledged descriptor address |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_rd` |
| tx_valid | output | 1 | Stream item valid |
| tx_data | output | 8 | Stream byte (0 for zero-length packets) |
| tx_sop | output | 1 | First item of a packet |
| tx_eop | output | 1 | Last item of a packet |
| tx_zlp | output | 1 | Item is a zero-length packet |
| busy | output | 1 | Engine is not idle |
| irq | output | 1 | Transmit completion interrupt |
| err | output | 1 | Sticky error flag |

## Verification
Timing from a head write is as follows:
- `busy` rises one clock after the head write.
- The first data byte appears seven cycles later: four descriptor reads, one evaluation, one word fetch and one latch.
- Each further byte follows on the next cycle, except that every word boundary costs two idle cycles.
- The mode write-back, `irq` and the end-of-queue idle all land in the cycle after the last byte or zero-length packet.

The scoreboard compares stream items in order on every valid cycle, so it does not depend on gap lengths. Checks on write-back, `irq` and `err` are sampled on the falling edge after `busy` has dropped. Completion-port effects are sampled one falling edge after the write is clocked in.

// File: rtl/tdma_pkg.sv
package tdma_pkg;
    localparam int MODE_SOF = 31;
    localparam int MODE_EOF = 30;
    localparam int MODE_OWN = 29;
    localparam int MODE_EOQ = 28;
    localparam int MODE_ZLP = 23;

    localparam int OFS_NEXT = 0;
    localparam int OFS_BUF  = 1;
    localparam int OFS_LEN  = 2;
    localparam int OFS_MODE = 3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_NEXT,
        ST_RD_BUF,
        ST_RD_LEN,
        ST_RD_MODE,
        ST_EVAL,
        ST_FETCH,
        ST_LATCH,
        ST_EMIT,
        ST_ZLP,
        ST_RETIRE
    } tdma_state_e;
endpackage

// File: rtl/tdma_lane_pick.sv
module tdma_lane_pick #(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8,
    localparam int SEL_W = $clog2(LANES)
) (
    input  logic [LANES*BYTE_W-1:0] word,
    input  logic [SEL_W-1:0]        lane,
    output logic [BYTE_W-1:0]       byte_out
);
    logic [BYTE_W-1:0] lanes_a [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes_a[g] = word[g*BYTE_W +: BYTE_W];
    end

    assign byte_out = lanes_a[lane];
endmodule

// File: rtl/tdma_pkt_track.sv
module tdma_pkt_track #(
    parameter int PKT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             fire,
    input  logic             last_byte,
    input  logic             frame_end,
    input  logic [PKT_W-1:0] max_pkt,
    output logic             sop,
    output logic             eop
);
    logic [PKT_W-1:0] cnt_q;

    assign sop = (cnt_q == '0);
    assign eop = (cnt_q == max_pkt - PKT_W'(1)) || (last_byte && frame_end);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (fire) begin
            cnt_q <= eop ? '0 : cnt_q + PKT_W'(1);
        end
    end
endmodule

// File: rtl/tdma_ctrl_regs.sv
module tdma_ctrl_regs #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle,
    input  logic              hdp_wr,
    input  logic [ADDR_W-1:0] hdp_wdata,
    input  logic              cmpl_wr,
    input  logic [ADDR_W-1:0] cmpl_wdata,
    input  logic              rel_valid,
    input  logic [ADDR_W-1:0] rel_addr,
    input  logic              zlp_bad,
    output logic              start,
    output logic              irq,
    output logic              err
);
    logic [ADDR_W-1:0] last_rel_q;

    assign start = hdp_wr && idle && (hdp_wdata != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq        <= 1'b0;
            err        <= 1'b0;
            last_rel_q <= '0;
        end else begin
            if ((hdp_wr && !idle) || zlp_bad) begin
                err <= 1'b1;
            end
            if (rel_valid) begin
                irq        <= 1'b1;
                last_rel_q <= rel_addr;
            end else if (cmpl_wr && (cmpl_wdata == last_rel_q)) begin
                irq <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tdma_engine.sv
module tdma_engine
    import tdma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PKT_W  = 11,
    localparam int BA_W  = ADDR_W + 2,
    localparam int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PKT_W-1:0]  cfg_max_pkt,
    input  logic              hdp_wr,
    input  logic [ADDR_W-1:0] hdp_wdata,
    input  logic              cmpl_wr,
    input  logic [ADDR_W-1:0] cmpl_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_sop,
    output logic              tx_eop,
    output logic              tx_zlp,
    output logic              busy,
    output logic              irq,
    output logic              err
);
    tdma_state_e       state_q, state_d;
    logic [ADDR_W-1:0] desc_q, next_q;
    logic [BA_W-1:0]   baddr_q;
    logic [LEN_W-1:0]  rem_q, zrem_q;
    logic [31:0]       mode_q, word_q;
    logic              bufnz_q;

    logic start, zlp_bad, trk_sop, trk_eop, restart;
    logic [7:0] lane_byte;
    logic [LEN_W-1:0] mps_ext;

    assign mps_ext = LEN_W'(cfg_max_pkt);
    assign restart = (state_q == ST_EVAL) && mem_rdata[MODE_OWN] && mem_rdata[MODE_SOF];
    assign zlp_bad = (state_q == ST_EVAL) && mem_rdata[MODE_OWN] && mem_rdata[MODE_ZLP] && !bufnz_q;

    tdma_ctrl_regs #(.ADDR_W(ADDR_W)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .idle       (state_q == ST_IDLE),
        .hdp_wr     (hdp_wr),
        .hdp_wdata  (hdp_wdata),
        .cmpl_wr    (cmpl_wr),
        .cmpl_wdata (cmpl_wdata),
        .rel_valid  (state_q == ST_RETIRE),
        .rel_addr   (desc_q),
        .zlp_bad    (zlp_bad),
        .start      (start),
        .irq        (irq),
        .err        (err)
    );

    tdma_lane_pick #(.LANES(4), .BYTE_W(8)) i_lane (
        .word     (word_q),
        .lane     (baddr_q[1:0]),
        .byte_out (lane_byte)
    );

    tdma_pkt_track #(.PKT_W(PKT_W)) i_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .fire      (state_q == ST_EMIT),
        .last_byte (rem_q == LEN_W'(1)),
        .frame_end (mode_q[MODE_EOF]),
        .max_pkt   (cfg_max_pkt),
        .sop       (trk_sop),
        .eop       (trk_eop)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_RD_NEXT;
            ST_RD_NEXT: state_d = ST_RD_BUF;
            ST_RD_BUF:  state_d = ST_RD_LEN;
            ST_RD_LEN:  state_d = ST_RD_MODE;
            ST_RD_MODE: state_d = ST_EVAL;
            ST_EVAL: begin
                if (!mem_rdata[MODE_OWN])      state_d = ST_IDLE;
                else if (mem_rdata[MODE_ZLP])  state_d = bufnz_q ? ST_ZLP : ST_RETIRE;
                else if (rem_q == '0)          state_d = ST_RETIRE;
                else                           state_d = ST_FETCH;
            end
            ST_FETCH:   state_d = ST_LATCH;
            ST_LATCH:   state_d = ST_EMIT;
            ST_EMIT: begin
                if (rem_q == LEN_W'(1))        state_d = ST_RETIRE;
                else if (baddr_q[1:0] == 2'b11) state_d = ST_FETCH;
                else                           state_d = ST_EMIT;
            end
            ST_ZLP:     state_d = (zrem_q > mps_ext) ? ST_ZLP : ST_RETIRE;
            ST_RETIRE:  state_d = (next_q == '0) ? ST_IDLE : ST_RD_NEXT;
            default:    state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc_q  <= '0;
            next_q  <= '0;
            baddr_q <= '0;
            rem_q   <= '0;
            zrem_q  <= '0;
            mode_q  <= '0;
            word_q  <= '0;
            bufnz_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE:    if (start) desc_q <= hdp_wdata;
                ST_RD_BUF:  next_q <= mem_rdata[ADDR_W-1:0];
                ST_RD_LEN: begin
                    baddr_q <= mem_rdata[BA_W-1:0];
                    bufnz_q <= |mem_rdata;
                end
                ST_RD_MODE: begin
                    baddr_q <= baddr_q + BA_W'(mem_rdata[31:16]);
                    rem_q   <= mem_rdata[LEN_W-1:0];
                    zrem_q  <= mem_rdata[LEN_W-1:0];
                end
                ST_EVAL:    mode_q <= mem_rdata;
                ST_LATCH:   word_q <= mem_rdata;
                ST_EMIT: begin
                    baddr_q <= baddr_q + BA_W'(1);
                    rem_q   <= rem_q - LEN_W'(1);
                end
                ST_ZLP:     if (zrem_q > mps_ext) zrem_q <= zrem_q - mps_ext;
                ST_RETIRE:  desc_q <= next_q;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        tx_valid  = 1'b0;
        tx_data   = '0;
        tx_sop    = 1'b0;
        tx_eop    = 1'b0;
        tx_zlp    = 1'b0;
        unique case (state_q)
            ST_RD_NEXT: begin mem_rd = 1'b1; mem_addr = desc_q + ADDR_W'(OFS_NEXT); end
            ST_RD_BUF:  begin mem_rd = 1'b1; mem_addr = desc_q + ADDR_W'(OFS_BUF);  end
            ST_RD_LEN:  begin mem_rd = 1'b1; mem_addr = desc_q + ADDR_W'(OFS_LEN);  end
            ST_RD_MODE: begin mem_rd = 1'b1; mem_addr = desc_q + ADDR_W'(OFS_MODE); end
            ST_FETCH:   begin mem_rd = 1'b1; mem_addr = baddr_q[BA_W-1:2]; end
            ST_EMIT: begin
                tx_valid = 1'b1;
                tx_data  = lane_byte;
                tx_sop   = trk_sop;
                tx_eop   = trk_eop;
            end
            ST_ZLP: begin
                tx_valid = 1'b1;
                tx_sop   = 1'b1;
                tx_eop   = 1'b1;
                tx_zlp   = 1'b1;
            end
            ST_RETIRE: begin
                mem_wr    = 1'b1;
                mem_addr  = desc_q + ADDR_W'(OFS_MODE);
                mem_wdata = mode_q;
                mem_wdata[MODE_OWN] = 1'b0;
                if (next_q == '0) mem_wdata[MODE_EOQ] = 1'b1;
            end
            default: ;
        endcase
    end

    assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/tdma_engine_chk.sv
module tdma_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic hdp_wr,
    input logic busy,
    input logic err,
    input logic irq,
    input logic mem_rd,
    input logic mem_wr,
    input logic wr_own,
    input logic wr_eoq,
    input logic tx_valid,
    input logic tx_sop,
    input logic tx_eop,
    input logic tx_zlp
);
    assert_busy_write_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && hdp_wr) |=> err);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    assert_release_clears_own_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> !wr_own);

    assert_eoq_goes_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && wr_eoq) |=> !busy);

    assert_zlp_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_zlp |-> (tx_valid && tx_sop && tx_eop));

    assert_irq_from_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(mem_wr));

    assert_one_access_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
endmodule

bind tdma_engine tdma_engine_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hdp_wr   (hdp_wr),
    .busy     (busy),
    .err      (err),
    .irq      (irq),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .wr_own   (mem_wdata[29]),
    .wr_eoq   (mem_wdata[28]),
    .tx_valid (tx_valid),
    .tx_sop   (tx_sop),
    .tx_eop   (tx_eop),
    .tx_zlp   (tx_zlp)
);

// File: tb/test_tdma_engine.sv
`timescale 1ns/1ps
module test_tdma_engine;
    localparam int ADDR_W = 16;
    localparam int PKT_W  = 11;
    localparam logic [31:0] SOF = 32'h8000_0000;
    localparam logic [31:0] EOF = 32'h4000_0000;
    localparam logic [31:0] OWN = 32'h2000_0000;
    localparam logic [31:0] EOQ = 32'h1000_0000;
    localparam logic [31:0] ZLP = 32'h0080_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [PKT_W-1:0] cfg_max_pkt = PKT_W'(4);
    logic hdp_wr = 1'b0, cmpl_wr = 1'b0;
    logic [ADDR_W-1:0] hdp_wdata = '0, cmpl_wdata = '0;
    logic mem_rd, mem_wr;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic tx_valid, tx_sop, tx_eop, tx_zlp, busy, irq, err;
    logic [7:0] tx_data;

    logic [31:0] mem [0:255];

    int checks = 0;
    int errors = 0;
    int m_cnt  = 0;

    typedef struct packed {
        logic [7:0] d;
        logic       sop;
        logic       eop;
        logic       zlp;
    } item_t;
    item_t exp_q[$];
    string req_q[$];

    always #2 clk = ~clk;

    tdma_engine #(.ADDR_W(ADDR_W), .PKT_W(PKT_W)) i_tdma_engine (
        .clk(clk), .rst_n(rst_n), .cfg_max_pkt(cfg_max_pkt),
        .hdp_wr(hdp_wr), .hdp_wdata(hdp_wdata),
        .cmpl_wr(cmpl_wr), .cmpl_wdata(cmpl_wdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_sop(tx_sop),
        .tx_eop(tx_eop), .tx_zlp(tx_zlp), .busy(busy), .irq(irq), .err(err)
    );

    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int b);
        return 8'(b * 13 + 7);
    endfunction

    // monitor: compare each stream item with the scoreboard
    always @(negedge clk) begin
        if (rst_n && tx_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9", "unexpected stream item", {tx_data, tx_sop, tx_eop, tx_zlp}, 0);
            end else begin
                item_t e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                check({tx_data, tx_sop, tx_eop, tx_zlp} == e, r, "stream item",
                      {tx_data, tx_sop, tx_eop, tx_zlp}, e);
            end
        end
    end

    task automatic put_desc(input int a, input int nxt, input int bp,
                            input int ofs, input int len, input logic [31:0] mode);
        mem[a]   = 32'(nxt);
        mem[a+1] = 32'(bp);
        mem[a+2] = {16'(ofs), 16'(len)};
        mem[a+3] = mode;
    endtask

    // driver: expected bytes for one descriptor from R1/R2
    task automatic exp_desc(input int ba, input int len, input bit sof,
                            input bit eof, input string req);
        if (sof) m_cnt = 0;
        for (int k = 0; k < len; k++) begin
            item_t it;
            int b;
            b = ba + k;
            it.d   = mem[(b >> 2) & 255][8*(b & 3) +: 8];
            it.sop = (m_cnt == 0);
            it.eop = (m_cnt == int'(cfg_max_pkt) - 1) || (k == len - 1 && eof);
            it.zlp = 1'b0;
            m_cnt  = it.eop ? 0 : m_cnt + 1;
            exp_q.push_back(it);
            req_q.push_back(req);
        end
    endtask

    task automatic exp_zlp(input int n);
        for (int k = 0; k < n; k++) begin
            exp_q.push_back(item_t'{d: 8'h00, sop: 1'b1, eop: 1'b1, zlp: 1'b1});
            req_q.push_back("R6");
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_cnt = 0;
        @(negedge clk);
    endtask

    task automatic start(input int a);
        @(negedge clk);
        hdp_wr = 1'b1;
        hdp_wdata = ADDR_W'(a);
        @(negedge clk);
        hdp_wr = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic cmpl(input int a);
        @(negedge clk);
        cmpl_wr = 1'b1;
        cmpl_wdata = ADDR_W'(a);
        @(negedge clk);
        cmpl_wr = 1'b0;
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R11", "watchdog expired", 0, 1);
        finish_sim();
    end

    initial begin
        for (int w = 0; w < 256; w++) mem[w] = '0;
        for (int w = 64; w < 160; w++)
            for (int l = 0; l < 4; l++) mem[w][8*l +: 8] = pat(4*w + l);

        do_reset();
        check(!busy && !irq && !err && !tx_valid && !mem_rd && !mem_wr, "R11",
              "reset outputs", {busy, irq, err, tx_valid, mem_rd, mem_wr}, 0);

        // single descriptor, split at max packet, end of queue
        put_desc(16, 0, 256, 0, 6, SOF | EOF | OWN | 32'd6);
        exp_desc(256, 6, 1'b1, 1'b1, "R2");
        start(16);
        wait_idle();
        check(exp_q.size() == 0, "R1", "items left", exp_q.size(), 0);
        check(mem[19] == (SOF | EOF | EOQ | 32'd6), "R5", "eoq write-back", mem[19], SOF | EOF | EOQ | 32'd6);
        check(irq == 1'b1, "R8", "irq after release", irq, 1);

        cmpl(20);
        check(irq == 1'b1, "R8", "irq kept on wrong pointer", irq, 1);
        cmpl(16);
        check(irq == 1'b0, "R8", "irq cleared", irq, 0);

        // chain with unaligned start, packet spans descriptors; restart after eoq
        put_desc(32, 36, 257, 2, 3, SOF | OWN | 32'd3);
        put_desc(36, 0, 384, 0, 3, EOF | OWN | 32'd3);
        exp_desc(259, 3, 1'b1, 1'b0, "R1");
        exp_desc(384, 3, 1'b0, 1'b1, "R2");
        start(32);
        wait_idle();
        check(exp_q.size() == 0, "R2", "items left", exp_q.size(), 0);
        check(mem[35] == (SOF | 32'd3), "R4", "mid-chain write-back", mem[35], SOF | 32'd3);
        check(mem[39] == (EOF | EOQ | 32'd3), "R5", "tail write-back", mem[39], EOF | EOQ | 32'd3);
        cmpl(32);
        check(irq == 1'b1, "R8", "older pointer keeps irq", irq, 1);
        cmpl(36);
        check(irq == 1'b0, "R8", "last pointer clears irq", irq, 0);

        // zero-length packet descriptors
        put_desc(48, 52, 512, 0, 1, SOF | EOF | OWN | ZLP | 32'd1);
        put_desc(52, 0, 512, 0, 9, OWN | ZLP | 32'd9);
        exp_zlp(1);
        exp_zlp(3);
        start(48);
        wait_idle();
        check(exp_q.size() == 0, "R6", "zlp items left", exp_q.size(), 0);
        check(mem[51] == (SOF | EOF | ZLP | 32'd1), "R6", "zlp write-back", mem[51], SOF | EOF | ZLP | 32'd1);
        check(mem[55] == (ZLP | EOQ | 32'd9), "R6", "zlp tail write-back", mem[55], ZLP | EOQ | 32'd9);
        check(err == 1'b0, "R6", "no error on valid zlp", err, 0);
        cmpl(52);

        // zero length data descriptor then data
        put_desc(56, 60, 256, 0, 0, EOF | OWN);
        put_desc(60, 0, 260, 0, 2, SOF | EOF | OWN | 32'd2);
        exp_desc(260, 2, 1'b1, 1'b1, "R10");
        start(56);
        wait_idle();
        check(exp_q.size() == 0, "R10", "items left", exp_q.size(), 0);
        check(mem[59] == EOF, "R10", "empty descriptor released", mem[59], EOF);
        cmpl(60);

        // unowned descriptor
        put_desc(68, 0, 256, 0, 4, SOF | EOF | 32'd4);
        start(68);
        wait_idle();
        check(mem[71] == (SOF | EOF | 32'd4), "R3", "unowned untouched", mem[71], SOF | EOF | 32'd4);
        check(irq == 1'b0, "R3", "no irq on unowned", irq, 0);

        // zlp with zero buffer pointer
        put_desc(72, 0, 0, 0, 1, OWN | ZLP | 32'd1);
        start(72);
        wait_idle();
        check(err == 1'b1, "R7", "err on null zlp buffer", err, 1);
        check(mem[75] == (ZLP | EOQ | 32'd1), "R7", "null zlp released", mem[75], ZLP | EOQ | 32'd1);
        check(irq == 1'b1, "R7", "irq on null zlp", irq, 1);

        do_reset();
        check(!err && !irq, "R11", "flags cleared by reset", {err, irq}, 0);

        // head write while busy
        put_desc(80, 0, 256, 0, 40, SOF | EOF | OWN | 32'd40);
        put_desc(84, 0, 300, 0, 5, SOF | EOF | OWN | 32'd5);
        exp_desc(256, 40, 1'b1, 1'b1, "R9");
        start(80);
        repeat (3) @(negedge clk);
        start(84);
        wait_idle();
        check(exp_q.size() == 0, "R9", "items left", exp_q.size(), 0);
        check(err == 1'b1, "R9", "err after busy write", err, 1);
        check(mem[87] == (SOF | EOF | OWN | 32'd5), "R9", "ignored head untouched", mem[87], SOF | EOF | OWN | 32'd5);
        repeat (4) @(negedge clk);
        check(err == 1'b1, "R9", "err sticky", err, 1);

        // head write of zero in idle
        start(0);
        check(!busy, "R5", "zero head ignored", busy, 0);

        finish_sim();
    end
endmodule